// File: doc/BRIEF.md
# Board Identification and Control Register Block

This block is a small memory-mapped register window for an FPGA evaluation board. Software reads two fixed identification words from it: a build-date code and the processor clock frequency in hertz. It also drives a bank of LEDs, reads a bank of DIP switches, and can ask the board to reset itself.

The bus side is a plain single-cycle register port. Address, write strobe, write data and read strobe are sampled on a rising clock edge. Read data appears registered in the following cycle. The window covers 64 KiB of byte addresses. Decode looks at the whole word offset inside the window and drops the two lowest address bits, so every access is a 32-bit word access.

A board reset is requested only when the exact value 0x0000DEAD is written to the reset-control word. The request is a one-cycle pulse on the output, and a separate reset sequencer acts on it. The switch inputs are asynchronous to the clock and pass through a two-stage synchronizer before software can see them.

Top module: `board_regs`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `led_out` is zero, `reset_req` is low and `bus_rdata` is zero.
- R2: A read of byte offset 0x0 returns the build-date constant 0x09272011 in the cycle after the read strobe.
- R3: A read of byte offset 0x4 returns the clock-frequency constant 10,000,000 (0x00989680).
- R4: A write to byte offset 0x8 loads `bus_wdata[LED_W-1:0]` into the LED register, which drives `led_out` from the next cycle (1 = lit, 0 = dark). A read of 0x8 returns the LED register zero-extended to 32 bits, so write-data bits above LED_W read back as zero.
- R5: A read of byte offset 0xC returns the synchronized switch state zero-extended to 32 bits (1 = on). A write to 0xC changes neither the LED register nor the switch readback.
- R6: A write of exactly 0x0000DEAD to byte offset 0x10 makes `reset_req` high for the one cycle after the write edge. It then falls again unless another such write occurs.
- R7: A write of any other value to offset 0x10 leaves `reset_req` low. A read of 0x10 returns zero.
- R8: A read of any byte offset other than 0x0, 0x4, 0x8 and 0xC returns zero, including offsets whose low bits match a register but whose upper bits do not. A write to any offset other than 0x8 leaves the LED register unchanged.
- R9: Address bits [1:0] do not affect decoding. For example, an access to 0x9 or 0xB reaches the LED register.
- R10: `bus_rdata` is registered. It holds the selected word in the cycle after a read strobe and is zero in any cycle that does not follow a read strobe.
- R11: A change on `sw_in` becomes visible to reads with two cycles of latency. Read strobes on the first and second rising edges after the change still return the old value, and a read on the third edge returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| led_out | output | LED_W | LED drive, 1 = lit |
| sw_in | input | SW_W | Asynchronous DIP-switch inputs, 1 = on |
| reset_req | output | 1 | One-cycle board-reset request |

## Verification
The bench builds the block with LED_W = 12 and SW_W = 6 rather than byte widths. With these widths, truncation of LED write data and zero-extension of both readbacks land on a boundary that is not a byte boundary, so an off-by-one slice shows up as a wrong bit. The default 16-bit window lets the bench probe an aliased offset (0x8008) and the top word (0xFFFC) to show that the upper address bits take part in decoding.

// File: rtl/board_regs_pkg.sv
package board_regs_pkg;
  // Byte offsets inside the window; software depends on these positions.
  localparam logic [31:0] OFF_DATE  = 32'h0000_0000;
  localparam logic [31:0] OFF_CLK   = 32'h0000_0004;
  localparam logic [31:0] OFF_LED   = 32'h0000_0008;
  localparam logic [31:0] OFF_SW    = 32'h0000_000C;
  localparam logic [31:0] OFF_RESET = 32'h0000_0010;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATE,
    SEL_CLK,
    SEL_LED,
    SEL_SW,
    SEL_RESET
  } reg_sel_e;
endpackage

// File: rtl/board_sync.sv
module board_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/board_decode.sv
module board_decode
  import board_regs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [1:0]        unused_lane;

  assign word        = addr[ADDR_W-1:2];
  assign unused_lane = addr[1:0];

  always_comb begin
    if      (word == WORD_W'(OFF_DATE  >> 2)) sel = SEL_DATE;
    else if (word == WORD_W'(OFF_CLK   >> 2)) sel = SEL_CLK;
    else if (word == WORD_W'(OFF_LED   >> 2)) sel = SEL_LED;
    else if (word == WORD_W'(OFF_SW    >> 2)) sel = SEL_SW;
    else if (word == WORD_W'(OFF_RESET >> 2)) sel = SEL_RESET;
    else                                      sel = SEL_NONE;
  end
endmodule

// File: rtl/board_regs.sv
module board_regs
  import board_regs_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int          LED_W      = 8,
  parameter int          SW_W       = 8,
  parameter int          SYNC_DEPTH = 2,
  parameter logic [31:0] BUILD_CODE = 32'h0927_2011,
  parameter logic [31:0] CLK_HZ     = 32'd10_000_000,
  parameter logic [31:0] MAGIC      = 32'h0000_DEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LED_W-1:0]  led_out,
  input  logic [SW_W-1:0]   sw_in,
  output logic              reset_req
);
  logic [SW_W-1:0]   sw_sync;
  reg_sel_e          sel;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              pulse_q;
  logic              magic_hit;

  board_sync #(.W(SW_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sw_in),
    .q   (sw_sync)
  );

  board_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign magic_hit = (bus_wdata == DATA_W'(MAGIC));

  always_comb begin
    case (sel)
      SEL_DATE: rd_mux = DATA_W'(BUILD_CODE);
      SEL_CLK:  rd_mux = DATA_W'(CLK_HZ);
      SEL_LED:  rd_mux = DATA_W'(led_q);
      SEL_SW:   rd_mux = DATA_W'(sw_sync);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q   <= '0;
      rdata_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (bus_wr && sel == SEL_LED) led_q <= bus_wdata[LED_W-1:0];
      pulse_q <= bus_wr && (sel == SEL_RESET) && magic_hit;
      rdata_q <= bus_rd ? rd_mux : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign led_out   = led_q;
  assign reset_req = pulse_q;
endmodule

// File: rtl/board_regs_chk.sv
module board_regs_chk
  import board_regs_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int          LED_W      = 8,
  parameter logic [31:0] BUILD_CODE = 32'h0927_2011,
  parameter logic [31:0] MAGIC      = 32'h0000_DEAD
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LED_W-1:0]  led_out,
  input logic              reset_req
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] w;
  assign w = bus_addr[ADDR_W-1:2];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (led_out == '0 && !reset_req && bus_rdata == '0));

  assert_date_read_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && w == WORD_W'(OFF_DATE >> 2)) |=> bus_rdata == DATA_W'(BUILD_CODE));

  assert_led_load_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && w == WORD_W'(OFF_LED >> 2)) |=> led_out == $past(bus_wdata[LED_W-1:0]));

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> ($past(bus_wr) && $past(w) == WORD_W'(OFF_RESET >> 2)
                   && $past(bus_wdata) == DATA_W'(MAGIC)));

  assert_led_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && w == WORD_W'(OFF_LED >> 2)) |=> $stable(led_out));

  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
endmodule

bind board_regs board_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W),
  .BUILD_CODE(BUILD_CODE), .MAGIC(MAGIC)
) u_chk (.*);

// File: tb/board_regs_test.sv
module board_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LED_W  = 12;
  localparam int SW_W   = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic [LED_W-1:0]  led_out;
  logic [SW_W-1:0]   sw_in = '0;
  logic              reset_req;

  int checks = 0;
  int errors = 0;

  board_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W), .SW_W(SW_W)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .led_out(led_out), .sw_in(sw_in), .reset_req(reset_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Write: strobe spans one rising edge; returns reset_req seen after it.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, output logic pulse);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    pulse = reset_req;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    check("R1 led after reset", 32'(led_out), 32'h0);
    check("R1 reset_req after reset", 32'(reset_req), 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    rd(16'h0000, d); check("R2 date word", d, 32'h0927_2011);
    rd(16'h0004, d); check("R3 clock word", d, 32'h0098_9680);
    @(negedge clk);
    check("R10 rdata zero after idle cycle", bus_rdata, 32'h0);
  endtask

  task automatic t_led();
    logic [31:0] d; logic p;
    wr(16'h0008, 32'hFFFF_FA5C, p);
    check("R4 led_out after write", 32'(led_out), 32'h0000_0A5C);
    rd(16'h0008, d); check("R4 led readback zero-extended", d, 32'h0000_0A5C);
    wr(16'h000B, 32'h0000_0123, p);
    check("R9 low addr bits ignored on write", 32'(led_out), 32'h0000_0123);
    rd(16'h0009, d); check("R9 low addr bits ignored on read", d, 32'h0000_0123);
  endtask

  task automatic t_switch();
    logic [31:0] d; logic p;
    @(negedge clk); sw_in = 6'h2B;
    repeat (3) @(negedge clk);
    rd(16'h000C, d); check("R5 switch readback", d, 32'h0000_002B);
    wr(16'h000C, 32'h0000_0FFF, p);
    check("R5 write to switch word leaves led", 32'(led_out), 32'h0000_0123);
    rd(16'h000C, d); check("R5 write to switch word leaves switches", d, 32'h0000_002B);
  endtask

  task automatic t_sync_latency();
    logic [31:0] d0, d1, d2;
    // Change switches and read at the 1st, 2nd, 3rd rising edges after.
    @(negedge clk);
    sw_in = 6'h14; bus_addr = 16'h000C; bus_rd = 1'b1;
    @(negedge clk); d0 = bus_rdata;
    @(negedge clk); d1 = bus_rdata;
    @(negedge clk); d2 = bus_rdata;
    bus_rd = 1'b0;
    check("R11 read at first edge old", d0, 32'h0000_002B);
    check("R11 read at second edge old", d1, 32'h0000_002B);
    check("R11 read at third edge new", d2, 32'h0000_0014);
  endtask

  task automatic t_reset_req();
    logic p; logic [31:0] d;
    wr(16'h0010, 32'h0000_DEAD, p);
    check("R6 pulse after magic write", 32'(p), 32'h1);
    @(negedge clk);
    check("R6 pulse lasts one cycle", 32'(reset_req), 32'h0);
    wr(16'h0010, 32'h0001_DEAD, p);
    check("R7 near-magic ignored", 32'(p), 32'h0);
    wr(16'h0010, 32'h0000_BEEF, p);
    check("R7 other value ignored", 32'(p), 32'h0);
    wr(16'h0008, 32'h0000_DEAD, p);
    check("R7 magic at led word no pulse", 32'(p), 32'h0);
    rd(16'h0010, d); check("R7 reset word reads zero", d, 32'h0);
    wr(16'h0008, 32'h0000_0123, p);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic p;
    rd(16'h0014, d); check("R8 read 0x14 zero", d, 32'h0);
    rd(16'h8008, d); check("R8 aliased 0x8008 reads zero", d, 32'h0);
    rd(16'hFFFC, d); check("R8 top word reads zero", d, 32'h0);
    wr(16'h8008, 32'h0000_0777, p);
    check("R8 aliased write drops", 32'(led_out), 32'h0000_0123);
    wr(16'h0000, 32'h0000_0555, p);
    rd(16'h0000, d); check("R8 write to date word dropped", d, 32'h0927_2011);
    check("R8 led unchanged after date write", 32'(led_out), 32'h0000_0123);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ident();
    t_led();
    t_switch();
    t_sync_latency();
    t_reset_req();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule